// File: doc/BRIEF.md
# PCI configuration access engine

This block sits between a processor and a PCI host bridge core and turns configuration requests into the parameters of a configuration cycle. A request names a bus, device, function, register offset and access size, plus a direction and whether it targets the host bridge's own configuration space (local) or a device on the bus (remote). The engine builds the configuration address, picks active-low byte-lane enables from the size and the low offset bits, composes the command word and lines write data up on the addressed lanes. It issues the cycle to a bus-side core, runs the data phase and hands back read data that has been shifted down and masked to the access width.

Bus errors are reported by the bus-side core on two error sources. A PCI-side source has two status bits and an AHB-side source has one. Each keeps its status bits, and the address of the first fault, until software writes the status bits back to clear them. Once the address and command have been issued, the engine checks the latched status. If any error is pending, it skips the data phase and returns a failure with all-ones data. A combination of size and offset that is not legal is rejected before any cycle is issued. A register window shows the last issued words and data and gives access to the error records.

Top module: `pcfg_engine`

## Requirements
- R1: A remote request with bus number 0 gives the address `(1 << dev) | (fn << 8) | (off & 0xFC)`: a one-hot bit at the device number, the function in bits 10:8 and the dword-aligned offset in bits 7:2, with bits 1:0 zero.
- R2: A remote request with a non-zero bus number gives the address `(bus << 16) | (dev << 11) | (fn << 8) | (off & 0xFC) | 1`.
- R3: The byte enables are active low and come from size and `off[1:0]`. Size 1 at offsets 0, 1, 2, 3 gives 0xE, 0xD, 0xB, 0x7. Size 2 gives 0xC at offset 0 and 0x3 at offset 2. Size 4 gives 0x0 at offset 0.
- R4: Every other size/offset combination is rejected. Size codes 0, 3, 5, 6 and 7 are never legal. The reply is then given one cycle after acceptance with `rsp_fail`=1 and `rsp_rdata`=0xFFFFFFFF, and no `cyc_start` is issued.
- R5: For a remote cycle, `cyc_cmd` holds 0xA (read) or 0xB (write) in bits 3:0 and the enables in bits 7:4, and all other bits are 0. For a local cycle, `cyc_cmd` is `(off & 0xFC) | (write << 16) | (enables << 20)`, and `cyc_addr` is 0. `cyc_start` is high for exactly one cycle.
- R6: During the data phase, `cyc_wdata` is the request data shifted left by 8×`off[1:0]`.
- R7: A successful read returns `(cyc_rdata >> 8*off[1:0])`, masked to 8, 16 or 32 bits for size 1, 2 or 4. A successful write returns 0 with `rsp_fail`=0.
- R8: If either error status is non-zero in the cycle after `cyc_start`, the data phase is skipped. `rsp_valid` then rises the next cycle with `rsp_fail`=1 and all-ones data.
- R9: Each error status ORs in its set bits (PCI 2 bits, AHB 1 bit). A register write of `reg_wbits` to its status offset clears those bits. The captured fault address is taken only when the status goes from zero to non-zero, and it stays frozen while the status is non-zero.
- R10: `busy` is high from acceptance until the reply. A request presented while `busy` is high is ignored and issues no cycle.
- R11: The register window reads the following, and any other offset reads 0:
  - 0x00: last local command word
  - 0x04: last local write data
  - 0x08: last raw local read data
  - 0x0C: last remote address
  - 0x10: last remote command word
  - 0x14: last remote write data
  - 0x18: last raw remote read data
  - 0x1C: PCI status
  - 0x20: PCI fault address
  - 0x24: AHB status
  - 0x28: AHB fault address

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = configuration write |
| req_local | input | 1 | 1 = host bridge's own configuration space |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device (slot) number |
| req_fn | input | 3 | Function number |
| req_off | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Engine occupied |
| rsp_valid | output | 1 | Reply strobe |
| rsp_fail | output | 1 | Rejected or aborted |
| rsp_rdata | output | 32 | Extracted read data |
| cyc_start | output | 1 | Address/command issue pulse |
| cyc_local | output | 1 | Issued cycle is local |
| cyc_write | output | 1 | Issued cycle writes |
| cyc_addr | output | 32 | Configuration address |
| cyc_cmd | output | 32 | Command / enable word |
| cyc_dvalid | output | 1 | Data phase active |
| cyc_wdata | output | 32 | Lane-aligned write data |
| cyc_ack | input | 1 | Data phase complete |
| cyc_rdata | input | 32 | Raw read data |
| pci_err_set | input | 2 | PCI-side error bits to set |
| pci_err_addr_in | input | 32 | Faulting PCI address |
| ahb_err_set | input | 1 | AHB-side error to set |
| ahb_err_addr_in | input | 32 | Faulting AHB address |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wbits | input | 2 | Status bits to clear |
| reg_rdata | output | 32 | Register read data |

## Verification
The bench sweeps every size code against every low offset, for local and remote cycles, both directions and zero and non-zero bus numbers. It targets the illegal pairs, which a design that skipped rejection would issue with nonsense enables, and the offsets 1 to 3 where a wrong shift would put data on the wrong lanes. It injects errors to check that the data phase is skipped; a design that ignored them would raise `cyc_dvalid` and return device data. A second error and a partial clear check that the fault address stays frozen, which a design that overwrote it would fail. A request presented mid-cycle checks that no second cycle starts.

// File: rtl/pcfg_pkg.sv
`timescale 1ns/1ps
package pcfg_pkg;
    localparam int DATA_W   = 32;
    localparam int BUS_W    = 8;
    localparam int DEV_W    = 5;
    localparam int FN_W     = 3;
    localparam int OFF_W    = 8;
    localparam int SIZE_W   = 3;
    localparam int BE_W     = 4;
    localparam int REG_AW   = 6;
    localparam int PCI_ST_W = 2;
    localparam int AHB_ST_W = 1;
    localparam int CLR_W    = (PCI_ST_W > AHB_ST_W) ? PCI_ST_W : AHB_ST_W;

    localparam int BUS_LSB      = 16;
    localparam int DEV1_LSB     = 11;
    localparam int FN_LSB       = 8;
    localparam int LOC_WR_BIT   = 16;
    localparam int BE_REM_LSB   = 4;
    localparam int BE_LOC_LSB   = 20;

    localparam logic [3:0] CMD_CFG_RD = 4'hA;
    localparam logic [3:0] CMD_CFG_WR = 4'hB;

    localparam logic [REG_AW-1:0] RA_LOC_CMD  = 6'h00;
    localparam logic [REG_AW-1:0] RA_LOC_WD   = 6'h04;
    localparam logic [REG_AW-1:0] RA_LOC_RD   = 6'h08;
    localparam logic [REG_AW-1:0] RA_REM_ADDR = 6'h0C;
    localparam logic [REG_AW-1:0] RA_REM_CMD  = 6'h10;
    localparam logic [REG_AW-1:0] RA_REM_WD   = 6'h14;
    localparam logic [REG_AW-1:0] RA_REM_RD   = 6'h18;
    localparam logic [REG_AW-1:0] RA_PCI_ST   = 6'h1C;
    localparam logic [REG_AW-1:0] RA_PCI_ADR  = 6'h20;
    localparam logic [REG_AW-1:0] RA_AHB_ST   = 6'h24;
    localparam logic [REG_AW-1:0] RA_AHB_ADR  = 6'h28;

    typedef struct packed {
        logic              write;
        logic              local_acc;
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FN_W-1:0]   fn;
        logic [OFF_W-1:0]  off;
        logic [SIZE_W-1:0] size;
        logic [DATA_W-1:0] wdata;
    } cfg_req_t;

    typedef struct packed {
        logic              legal;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] cmd;
        logic [DATA_W-1:0] wdata;
    } cyc_desc_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ISSUE, ST_CHECK, ST_DATA, ST_RESP
    } seq_state_t;

    // {legal, active-low enables}
    function automatic logic [BE_W:0] lane_enables(input logic [SIZE_W-1:0] size,
                                                   input logic [1:0] lo);
        logic [BE_W:0] r;
        r = {1'b0, 4'hF};
        case (size)
            3'd1: r = {1'b1, ~(4'b0001 << lo)};
            3'd2: if (!lo[0]) r = {1'b1, ~(4'b0011 << lo)};
            3'd4: if (lo == 2'd0) r = {1'b1, 4'h0};
            default: r = {1'b0, 4'hF};
        endcase
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_address(input logic [BUS_W-1:0] bus,
                                                      input logic [DEV_W-1:0] dev,
                                                      input logic [FN_W-1:0]  fn,
                                                      input logic [OFF_W-1:0] off);
        logic [DATA_W-1:0] dw_off;
        logic [DATA_W-1:0] fn_f;
        dw_off = DATA_W'({off[OFF_W-1:2], 2'b00});
        fn_f   = DATA_W'(fn) << FN_LSB;
        if (bus == '0)
            return (DATA_W'(1) << dev) | fn_f | dw_off;
        else
            return (DATA_W'(bus) << BUS_LSB) | (DATA_W'(dev) << DEV1_LSB)
                   | fn_f | dw_off | DATA_W'(1);
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input logic [SIZE_W-1:0] size);
        case (size)
            3'd1:    return DATA_W'(32'h0000_00FF);
            3'd2:    return DATA_W'(32'h0000_FFFF);
            default: return '1;
        endcase
    endfunction
endpackage

// File: rtl/pcfg_addr_gen.sv
`timescale 1ns/1ps
module pcfg_addr_gen
    import pcfg_pkg::*;
(
    input  cfg_req_t  req,
    output cyc_desc_t desc
);
    logic [BE_W:0]     le;
    logic [4:0]        lane_sh;
    logic [DATA_W-1:0] dw_off;

    always_comb begin
        le      = lane_enables(req.size, req.off[1:0]);
        lane_sh = {req.off[1:0], 3'b000};
        dw_off  = DATA_W'({req.off[OFF_W-1:2], 2'b00});

        desc.legal = le[BE_W];
        desc.be    = le[BE_W-1:0];
        desc.wdata = req.wdata << lane_sh;
        if (req.local_acc) begin
            desc.addr = '0;
            desc.cmd  = dw_off
                      | (DATA_W'(req.write) << LOC_WR_BIT)
                      | (DATA_W'(le[BE_W-1:0]) << BE_LOC_LSB);
        end else begin
            desc.addr = cfg_address(req.bus, req.dev, req.fn, req.off);
            desc.cmd  = (DATA_W'(le[BE_W-1:0]) << BE_REM_LSB)
                      | DATA_W'(req.write ? CMD_CFG_WR : CMD_CFG_RD);
        end
    end
endmodule

// File: rtl/pcfg_err_rec.sv
`timescale 1ns/1ps
module pcfg_err_rec
    import pcfg_pkg::*;
#(
    parameter int ST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ST_W-1:0]   set_bits,
    input  logic [DATA_W-1:0] set_addr,
    input  logic              clr_we,
    input  logic [ST_W-1:0]   clr_bits,
    output logic [ST_W-1:0]   status,
    output logic [DATA_W-1:0] cap_addr
);
    logic [ST_W-1:0] clr_eff;

    always_comb clr_eff = clr_we ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status   <= '0;
            cap_addr <= '0;
        end else begin
            status <= (status & ~clr_eff) | set_bits;
            if (status == '0 && set_bits != '0)
                cap_addr <= set_addr;
        end
    end

    // R9
    addr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (status != '0) |=> $stable(cap_addr));
endmodule

// File: rtl/pcfg_seq.sv
`timescale 1ns/1ps
module pcfg_seq
    import pcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_legal,
    input  logic              req_write,
    input  logic              req_local,
    input  logic [1:0]        req_off_lo,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] iss_addr,
    input  logic [DATA_W-1:0] iss_cmd,
    input  logic [DATA_W-1:0] iss_wdata,
    input  logic              err_any,
    input  logic              cyc_ack,
    input  logic [DATA_W-1:0] cyc_rdata,
    output logic              busy,
    output logic              cyc_start,
    output logic              cyc_local,
    output logic              cyc_write,
    output logic [DATA_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_cmd,
    output logic              cyc_dvalid,
    output logic [DATA_W-1:0] cyc_wdata,
    output logic              rsp_valid,
    output logic              rsp_fail,
    output logic [DATA_W-1:0] rsp_rdata
);
    seq_state_t        state;
    logic              l_write, l_local;
    logic [1:0]        l_lo;
    logic [SIZE_W-1:0] l_size;
    logic [DATA_W-1:0] l_addr, l_cmd, l_wdata;
    logic [DATA_W-1:0] extracted;

    always_comb extracted = (cyc_rdata >> {l_lo, 3'b000}) & size_mask(l_size);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            l_write   <= 1'b0;
            l_local   <= 1'b0;
            l_lo      <= '0;
            l_size    <= '0;
            l_addr    <= '0;
            l_cmd     <= '0;
            l_wdata   <= '0;
            rsp_fail  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    l_write <= req_write;
                    l_local <= req_local;
                    l_lo    <= req_off_lo;
                    l_size  <= req_size;
                    l_addr  <= iss_addr;
                    l_cmd   <= iss_cmd;
                    l_wdata <= iss_wdata;
                    if (req_legal) begin
                        state <= ST_ISSUE;
                    end else begin
                        state     <= ST_RESP;
                        rsp_fail  <= 1'b1;
                        rsp_rdata <= '1;
                    end
                end
                ST_ISSUE: state <= ST_CHECK;
                ST_CHECK: if (err_any) begin
                    state     <= ST_RESP;
                    rsp_fail  <= 1'b1;
                    rsp_rdata <= '1;
                end else begin
                    state <= ST_DATA;
                end
                ST_DATA: if (cyc_ack) begin
                    state     <= ST_RESP;
                    rsp_fail  <= 1'b0;
                    rsp_rdata <= l_write ? '0 : extracted;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = (state != ST_IDLE);
        cyc_start  = (state == ST_ISSUE);
        cyc_dvalid = (state == ST_DATA);
        rsp_valid  = (state == ST_RESP);
        cyc_local  = l_local;
        cyc_write  = l_write;
        cyc_addr   = l_addr;
        cyc_cmd    = l_cmd;
        cyc_wdata  = l_wdata;
    end

    // R8
    abort_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && err_any) |=> (rsp_valid && rsp_fail && !cyc_dvalid));
    // R5
    one_issue_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_start |=> !cyc_start);
    // R4
    fail_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fail) |-> (rsp_rdata == '1));
    // R10
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_dvalid && !cyc_ack) |=> (cyc_dvalid && busy));
endmodule

// File: rtl/pcfg_engine.sv
`timescale 1ns/1ps
module pcfg_engine
    import pcfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_local,
    input  logic [BUS_W-1:0]    req_bus,
    input  logic [DEV_W-1:0]    req_dev,
    input  logic [FN_W-1:0]     req_fn,
    input  logic [OFF_W-1:0]    req_off,
    input  logic [SIZE_W-1:0]   req_size,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                busy,
    output logic                rsp_valid,
    output logic                rsp_fail,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                cyc_start,
    output logic                cyc_local,
    output logic                cyc_write,
    output logic [DATA_W-1:0]   cyc_addr,
    output logic [DATA_W-1:0]   cyc_cmd,
    output logic                cyc_dvalid,
    output logic [DATA_W-1:0]   cyc_wdata,
    input  logic                cyc_ack,
    input  logic [DATA_W-1:0]   cyc_rdata,
    input  logic [PCI_ST_W-1:0] pci_err_set,
    input  logic [DATA_W-1:0]   pci_err_addr_in,
    input  logic [AHB_ST_W-1:0] ahb_err_set,
    input  logic [DATA_W-1:0]   ahb_err_addr_in,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [CLR_W-1:0]    reg_wbits,
    output logic [DATA_W-1:0]   reg_rdata
);
    cfg_req_t          req;
    cyc_desc_t         desc;
    logic [PCI_ST_W-1:0] pci_st;
    logic [AHB_ST_W-1:0] ahb_st;
    logic [DATA_W-1:0] pci_adr, ahb_adr;
    logic [DATA_W-1:0] v_loc_cmd, v_loc_wd, v_loc_rd;
    logic [DATA_W-1:0] v_rem_addr, v_rem_cmd, v_rem_wd, v_rem_rd;
    logic              accept;

    always_comb begin
        req.write     = req_write;
        req.local_acc = req_local;
        req.bus       = req_bus;
        req.dev       = req_dev;
        req.fn        = req_fn;
        req.off       = req_off;
        req.size      = req_size;
        req.wdata     = req_wdata;
        accept        = req_valid && !busy;
    end

    pcfg_addr_gen u_agen (.req(req), .desc(desc));

    pcfg_seq u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_legal(desc.legal),
        .req_write(req_write), .req_local(req_local),
        .req_off_lo(req_off[1:0]), .req_size(req_size),
        .iss_addr(desc.addr), .iss_cmd(desc.cmd), .iss_wdata(desc.wdata),
        .err_any((pci_st != '0) || (ahb_st != '0)),
        .cyc_ack(cyc_ack), .cyc_rdata(cyc_rdata),
        .busy(busy), .cyc_start(cyc_start), .cyc_local(cyc_local),
        .cyc_write(cyc_write), .cyc_addr(cyc_addr), .cyc_cmd(cyc_cmd),
        .cyc_dvalid(cyc_dvalid), .cyc_wdata(cyc_wdata),
        .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .rsp_rdata(rsp_rdata)
    );

    pcfg_err_rec #(.ST_W(PCI_ST_W)) u_pci_err (
        .clk(clk), .rst(rst),
        .set_bits(pci_err_set), .set_addr(pci_err_addr_in),
        .clr_we(reg_wr && reg_addr == RA_PCI_ST),
        .clr_bits(reg_wbits[PCI_ST_W-1:0]),
        .status(pci_st), .cap_addr(pci_adr)
    );

    pcfg_err_rec #(.ST_W(AHB_ST_W)) u_ahb_err (
        .clk(clk), .rst(rst),
        .set_bits(ahb_err_set), .set_addr(ahb_err_addr_in),
        .clr_we(reg_wr && reg_addr == RA_AHB_ST),
        .clr_bits(reg_wbits[AHB_ST_W-1:0]),
        .status(ahb_st), .cap_addr(ahb_adr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v_loc_cmd <= '0; v_loc_wd <= '0; v_loc_rd <= '0;
            v_rem_addr <= '0; v_rem_cmd <= '0; v_rem_wd <= '0; v_rem_rd <= '0;
        end else begin
            if (cyc_start) begin
                if (cyc_local) v_loc_cmd <= cyc_cmd;
                else begin
                    v_rem_addr <= cyc_addr;
                    v_rem_cmd  <= cyc_cmd;
                end
            end
            if (cyc_dvalid && cyc_write) begin
                if (cyc_local) v_loc_wd <= cyc_wdata;
                else           v_rem_wd <= cyc_wdata;
            end
            if (cyc_dvalid && cyc_ack && !cyc_write) begin
                if (cyc_local) v_loc_rd <= cyc_rdata;
                else           v_rem_rd <= cyc_rdata;
            end
        end
    end

    always_comb begin
        case (reg_addr)
            RA_LOC_CMD:  reg_rdata = v_loc_cmd;
            RA_LOC_WD:   reg_rdata = v_loc_wd;
            RA_LOC_RD:   reg_rdata = v_loc_rd;
            RA_REM_ADDR: reg_rdata = v_rem_addr;
            RA_REM_CMD:  reg_rdata = v_rem_cmd;
            RA_REM_WD:   reg_rdata = v_rem_wd;
            RA_REM_RD:   reg_rdata = v_rem_rd;
            RA_PCI_ST:   reg_rdata = DATA_W'(pci_st);
            RA_PCI_ADR:  reg_rdata = pci_adr;
            RA_AHB_ST:   reg_rdata = DATA_W'(ahb_st);
            RA_AHB_ADR:  reg_rdata = ahb_adr;
            default:     reg_rdata = '0;
        endcase
    end

    // R3
    lane_count_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && desc.legal) |-> ($countones(~desc.be) == int'(req_size)));
    // R4
    reject_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !desc.legal) |=> (rsp_valid && !cyc_start));
endmodule

// File: tb/pcfg_engine_tb.sv
`timescale 1ns/1ps
module pcfg_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0, req_write = 0, req_local = 0;
    logic [7:0]  req_bus = 0;
    logic [4:0]  req_dev = 0;
    logic [2:0]  req_fn = 0;
    logic [7:0]  req_off = 0;
    logic [2:0]  req_size = 0;
    logic [31:0] req_wdata = 0;
    logic        busy, rsp_valid, rsp_fail;
    logic [31:0] rsp_rdata;
    logic        cyc_start, cyc_local, cyc_write, cyc_dvalid;
    logic [31:0] cyc_addr, cyc_cmd, cyc_wdata;
    logic        cyc_ack = 0;
    logic [31:0] cyc_rdata = 0;
    logic [1:0]  pci_err_set = 0;
    logic [31:0] pci_err_addr_in = 0;
    logic [0:0]  ahb_err_set = 0;
    logic [31:0] ahb_err_addr_in = 0;
    logic        reg_wr = 0;
    logic [5:0]  reg_addr = 0;
    logic [1:0]  reg_wbits = 0;
    logic [31:0] reg_rdata;

    int vectors = 0, fails = 0, n_starts = 0, cyc_cnt = 0;

    always #2.5 clk = ~clk;

    pcfg_engine u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_local(req_local), .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn),
        .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .rsp_rdata(rsp_rdata),
        .cyc_start(cyc_start), .cyc_local(cyc_local), .cyc_write(cyc_write),
        .cyc_addr(cyc_addr), .cyc_cmd(cyc_cmd), .cyc_dvalid(cyc_dvalid),
        .cyc_wdata(cyc_wdata), .cyc_ack(cyc_ack), .cyc_rdata(cyc_rdata),
        .pci_err_set(pci_err_set), .pci_err_addr_in(pci_err_addr_in),
        .ahb_err_set(ahb_err_set), .ahb_err_addr_in(ahb_err_addr_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wbits(reg_wbits),
        .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (!rst && cyc_start) n_starts++;
        cyc_cnt++;
        if (cyc_cnt > 100000) begin
            fails++;
            $display("FAIL watchdog: run hung act=%0d cycles exp=finished", cyc_cnt);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rreg(input logic [5:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wreg(input logic [5:0] a, input logic [1:0] bits);
        @(negedge clk);
        reg_addr = a; reg_wbits = bits; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic txn(input bit loc, input bit wr, input logic [7:0] bus,
                       input logic [4:0] dev, input logic [2:0] fn,
                       input logic [7:0] off, input logic [2:0] size,
                       input logic [31:0] wd, input logic [31:0] rraw,
                       input logic [1:0] pinj, input logic [31:0] paddr,
                       input bit ainj, input logic [31:0] aaddr,
                       input bit abort_exp, input bit poke);
        int o;
        bit legal;
        logic [3:0]  be;
        logic [31:0] eaddr, ecmd, wsh, mask, rexp, v;
        int s0;
        string atag;
        o = int'(off[1:0]);
        legal = 0; be = 4'hF;
        case (size)
            3'd1: begin legal = 1; be = 4'hF ^ (4'h1 << o); end
            3'd2: begin legal = (o == 0 || o == 2); be = 4'hF ^ (4'h3 << o); end
            3'd4: begin legal = (o == 0); be = 4'h0; end
            default: legal = 0;
        endcase
        if (loc) eaddr = 0;
        else if (bus == 0)
            eaddr = (32'h1 << dev) | ({29'b0, fn} << 8) | {24'b0, off & 8'hFC};
        else
            eaddr = ({24'b0, bus} << 16) | ({27'b0, dev} << 11) | ({29'b0, fn} << 8)
                  | {24'b0, off & 8'hFC} | 32'h1;
        if (loc) ecmd = ({31'b0, wr} << 16) | ({28'b0, be} << 20) | {24'b0, off & 8'hFC};
        else     ecmd = {24'b0, be, (wr ? 4'hB : 4'hA)};
        wsh  = wd << (8 * o);
        mask = (size == 3'd4) ? 32'hFFFF_FFFF : 32'((64'h1 << (8 * size)) - 1);
        rexp = (rraw >> (8 * o)) & mask;
        atag = (bus == 0) ? "R1 address" : "R2 address";
        s0 = n_starts;

        @(negedge clk);
        req_local = loc; req_write = wr; req_bus = bus; req_dev = dev; req_fn = fn;
        req_off = off; req_size = size; req_wdata = wd; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        if (!legal) begin
            chk("R4 rsp_valid on reject", {31'b0, rsp_valid}, 1);
            chk("R4 rsp_fail on reject", {31'b0, rsp_fail}, 1);
            chk("R4 rdata on reject", rsp_rdata, 32'hFFFF_FFFF);
            chk("R4 no cycle issued", n_starts, s0);
            return;
        end
        chk("R5 cyc_start", {31'b0, cyc_start}, 1);
        chk(loc ? "R5 local addr" : atag, cyc_addr, eaddr);
        chk("R5 R3 command/enables", cyc_cmd, ecmd);
        chk("R5 cyc_local", {31'b0, cyc_local}, {31'b0, loc});
        chk("R10 busy during cycle", {31'b0, busy}, 1);
        if (poke) begin
            req_valid = 1; req_local = ~loc; req_off = off + 8'd4; req_size = 3'd4;
        end
        pci_err_set = pinj; pci_err_addr_in = paddr;
        ahb_err_set = ainj; ahb_err_addr_in = aaddr;
        @(negedge clk);
        req_valid = 0; pci_err_set = 0; ahb_err_set = 0;
        @(negedge clk);
        if (abort_exp) begin
            chk("R8 rsp_valid after abort", {31'b0, rsp_valid}, 1);
            chk("R8 no data phase", {31'b0, cyc_dvalid}, 0);
            chk("R8 rsp_fail", {31'b0, rsp_fail}, 1);
            chk("R8 rdata all ones", rsp_rdata, 32'hFFFF_FFFF);
        end else begin
            chk("R8 data phase entered", {31'b0, cyc_dvalid}, 1);
            chk("R6 lane-shifted wdata", cyc_wdata, wsh);
            cyc_ack = 1; cyc_rdata = rraw;
            @(negedge clk);
            cyc_ack = 0;
            chk("R7 rsp_valid", {31'b0, rsp_valid}, 1);
            chk("R7 rsp_fail", {31'b0, rsp_fail}, 0);
            chk("R7 extracted rdata", rsp_rdata, wr ? 32'h0 : rexp);
            if (loc) begin
                rreg(6'h00, v); chk("R11 local cmd reg", v, ecmd);
                if (wr) begin rreg(6'h04, v); chk("R11 local wdata reg", v, wsh); end
                else    begin rreg(6'h08, v); chk("R11 local rdata reg", v, rraw); end
            end else begin
                rreg(6'h0C, v); chk("R11 remote addr reg", v, eaddr);
                rreg(6'h10, v); chk("R11 remote cmd reg", v, ecmd);
                if (wr) begin rreg(6'h14, v); chk("R11 remote wdata reg", v, wsh); end
                else    begin rreg(6'h18, v); chk("R11 remote rdata reg", v, rraw); end
            end
        end
        chk("R10 exactly one cycle issued", n_starts, s0 + 1);
    endtask

    initial begin
        logic [31:0] v;
        int idx;
        repeat (4) @(negedge clk);
        rst = 0;
        chk("R10 busy after reset", {31'b0, busy}, 0);
        chk("R8 rsp_valid after reset", {31'b0, rsp_valid}, 0);
        chk("R5 cyc_start after reset", {31'b0, cyc_start}, 0);
        rreg(6'h1C, v); chk("R9 PCI status after reset", v, 0);
        rreg(6'h24, v); chk("R9 AHB status after reset", v, 0);
        rreg(6'h2C, v); chk("R11 unmapped offset", v, 0);

        idx = 0;
        for (int l = 0; l < 2; l++)
            for (int w = 0; w < 2; w++)
                for (int bz = 0; bz < 2; bz++)
                    for (int s = 0; s < 8; s++)
                        for (int o = 0; o < 4; o++) begin
                            logic [7:0] bus;
                            logic [7:0] off;
                            idx++;
                            if (l == 1 && bz == 1) continue;
                            bus = (bz == 1) ? 8'(1 + (idx % 254)) : 8'h00;
                            off = {6'(idx * 5), 2'(o)};
                            txn(l[0], w[0], bus, 5'((idx * 7) % 32), 3'(idx % 8), off,
                                3'(s), 32'hA5C3_0000 + 32'(idx * 257),
                                32'h1234_5678 ^ 32'(idx * 40503), 2'b00, 0, 0, 0, 0, 0);
                        end

        // error abort, sticky status, frozen address (R8, R9)
        txn(0, 0, 8'h00, 5'd3, 3'd1, 8'h10, 3'd4, 0, 32'hDEAD_BEEF,
            2'b01, 32'h0000_AAA0, 0, 0, 1, 0);
        rreg(6'h1C, v); chk("R9 PCI status set", v, 1);
        rreg(6'h20, v); chk("R9 PCI fault addr captured", v, 32'h0000_AAA0);
        txn(0, 1, 8'h02, 5'd4, 3'd2, 8'h20, 3'd2, 32'h55, 0,
            2'b10, 32'h0000_BBB0, 0, 0, 1, 0);
        rreg(6'h1C, v); chk("R9 PCI status accumulates", v, 3);
        rreg(6'h20, v); chk("R9 PCI fault addr frozen", v, 32'h0000_AAA0);
        wreg(6'h1C, 2'b01);
        rreg(6'h1C, v); chk("R9 partial clear", v, 2);
        rreg(6'h20, v); chk("R9 addr frozen after partial clear", v, 32'h0000_AAA0);
        wreg(6'h1C, 2'b10);
        rreg(6'h1C, v); chk("R9 full clear", v, 0);
        txn(0, 0, 8'h00, 5'd1, 3'd0, 8'h04, 3'd4, 0, 32'hCAFE_F00D, 0, 0, 0, 0, 0, 0);
        txn(1, 1, 8'h00, 5'd0, 3'd0, 8'h04, 3'd2, 32'h0106, 0,
            0, 0, 1, 32'h00C0_FFEE, 1, 0);
        rreg(6'h24, v); chk("R9 AHB status set", v, 1);
        rreg(6'h28, v); chk("R9 AHB fault addr", v, 32'h00C0_FFEE);
        wreg(6'h24, 2'b01);
        rreg(6'h24, v); chk("R9 AHB clear", v, 0);

        // request while busy is ignored (R10)
        txn(0, 0, 8'h05, 5'd9, 3'd3, 8'h42, 3'd1, 0, 32'h8899_AABB, 0, 0, 0, 0, 0, 1);
        repeat (3) @(negedge clk);
        chk("R10 no extra cycle after busy poke", {31'b0, busy}, 0);
        txn(1, 0, 8'h00, 5'd0, 3'd0, 8'h02, 3'd2, 0, 32'hF0E1_D2C3, 0, 0, 0, 0, 0, 1);
        repeat (3) @(negedge clk);
        chk("R10 idle after second poke", {31'b0, busy}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule